// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs single management transactions on a two-wire Ethernet PHY management bus. The system side raises a request with a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block divides its system clock down to the management clock (MDC). It then shifts the whole frame onto the data line (MDIO) and, for reads, collects the data the PHY returns. The pad is handled as three separate signals: an output value, an output enable and an input.

Every frame opens with a long run of ones for synchronisation. The block then sends the start and direction pattern and the two addresses, followed by either a turnaround and data driven by the master, or a released line from which the PHY's answer is taken. On reads the block checks that the PHY pulls the turnaround bit low. If the PHY does not, the block keeps clocking with the line released long enough for the PHY to lose any half-finished frame, then finishes with an error. A one-cycle done pulse closes every transaction, and the returned data and the error flag stay valid until the next request is accepted.

Top module: `mdio_master`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the block returns to idle: `busy_o`, `done_o`, `err_o`, `mdc_o` and `mdio_oe_o` are 0.
- R2: A request (`req_valid_i` high) is taken only when `busy_o` is low. A request raised while busy changes nothing: the running frame, its divider and its single done pulse stay as they were.
- R3: MDC cycles are numbered from 0 at the start of a frame. Cycles 0 to PRE_LEN-1 (32 by default) drive MDIO with 1 (`mdio_oe_o`=1, `mdio_o`=1).
- R4: The next two cycles carry the start bits 0 and then 1. The two cycles after those carry the direction code: 1 then 0 for a read (`req_read_i`=1), 0 then 1 for a write.
- R5: Cycles PRE_LEN+4 to PRE_LEN+8 carry the PHY address and cycles PRE_LEN+9 to PRE_LEN+13 carry the register address, each most significant bit first.
- R6: A write then drives 1, 0 as turnaround and the 16 data bits MSB first, and releases MDIO for one last cycle: PRE_LEN+33 MDC cycles in all.
- R7: From the turnaround cycle (PRE_LEN+14) onward a read leaves MDIO released. It samples MDIO at the end of each MDC high phase, expects 0 in the turnaround cycle and shifts 16 data bits MSB first into `rdata_o`. Two trailing cycles follow, for PRE_LEN+33 MDC cycles in all, and `err_o` is 0 at done.
- R8: If the read turnaround sample is 1, RECOV_LEN (32) more released MDC cycles follow, for PRE_LEN+15+RECOV_LEN cycles in all. Done then comes with `err_o`=1 and `rdata_o`=0.
- R9: `mdio_o` and `mdio_oe_o` change only while `mdc_o` is low; they are stable throughout every MDC high phase.
- R10: Each MDC low phase and each high phase lasts `div_i` system clocks, with `div_i` captured when the request is taken. `div_i`=0 selects the default ceil(SYS_CLK_KHZ/(2*MDC_MAX_KHZ)), which is 20 clocks at the default 100 MHz, giving 2.5 MHz.
- R11: `busy_o` is high from the clock after acceptance until `done_o`. `done_o` is a single-cycle pulse with `busy_o` already low. `mdc_o` is low whenever `busy_o` is low.
- R12: `rdata_o` and `err_o` keep their done-time values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken while idle |
| req_read_i | input | 1 | 1 = read, 0 = write |
| req_phy_i | input | 5 | PHY address |
| req_reg_i | input | 5 | Register address |
| req_wdata_i | input | 16 | Write data |
| div_i | input | DIV_W (8) | MDC phase length in system clocks, 0 = default |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Read turnaround was not driven low |
| rdata_o | output | 16 | Read data |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the block with its default parameters: a 32-bit preamble, a 32-cycle recovery, an 8-bit divider and a 100 MHz reference. This keeps the exact cycle counts of both normal frames and recovery frames within reach. The divider is driven at run time with small values (1 to 4) so that many frames fit in a short run: every PHY address and every register address passes through a write or a read, and walking data patterns are used. A frame with `div_i`=0 covers the computed default, and one frame changes the divider and raises a second request in mid-frame. A behavioural PHY in the bench answers reads, driving either a good or a bad turnaround, and every captured MDC cycle is compared with a frame built arithmetically from the request.

// File: rtl/mdio_master_pkg.sv
// Package: mdio_master_pkg
// Shared field widths, the per-bit drive encoding and the functions that
// place each field of a management frame on its MDC cycle index.
// Assumes the frame layout preamble / start / direction / PHY / register /
// turnaround / data, with the preamble length passed in by the caller.
package mdio_master_pkg;

    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;

    // Value placed on the pad for one MDC cycle.
    typedef struct packed {
        logic oe;
        logic o;
    } drive_t;

    // Role of a read-frame cycle seen from the receive side.
    typedef enum logic [1:0] {
        SL_HDR   = 2'd0,
        SL_TA    = 2'd1,
        SL_RDATA = 2'd2,
        SL_TAIL  = 2'd3
    } slot_e;

    // Pad drive for cycle k of a frame.
    function automatic drive_t frame_drive(
        input int                 pre_len,
        input logic               rd,
        input logic [PHY_W-1:0]   phy,
        input logic [REG_W-1:0]   ra,
        input logic [DATA_W-1:0]  wd,
        input int                 k
    );
        drive_t              d;
        logic [PHY_W-1:0]    pt;
        logic [REG_W-1:0]    rt;
        logic [DATA_W-1:0]   wt;
        int                  ta0;
        ta0  = pre_len + 4 + PHY_W + REG_W;
        d.oe = 1'b1;
        d.o  = 1'b1;
        pt   = '0;
        rt   = '0;
        wt   = '0;
        if (k < pre_len) begin
            d.o = 1'b1;
        end else if (k == pre_len) begin
            d.o = 1'b0;
        end else if (k == pre_len + 1) begin
            d.o = 1'b1;
        end else if (k == pre_len + 2) begin
            d.o = rd;
        end else if (k == pre_len + 3) begin
            d.o = ~rd;
        end else if (k < pre_len + 4 + PHY_W) begin
            pt  = phy << (k - pre_len - 4);
            d.o = pt[PHY_W-1];
        end else if (k < ta0) begin
            rt  = ra << (k - pre_len - 4 - PHY_W);
            d.o = rt[REG_W-1];
        end else if (rd) begin
            d.oe = 1'b0;
            d.o  = 1'b0;
        end else if (k == ta0) begin
            d.o = 1'b1;
        end else if (k == ta0 + 1) begin
            d.o = 1'b0;
        end else if (k < ta0 + 2 + DATA_W) begin
            wt  = wd << (k - ta0 - 2);
            d.o = wt[DATA_W-1];
        end else begin
            d.oe = 1'b0;
            d.o  = 1'b0;
        end
        return d;
    endfunction

    // Receive-side role of cycle k in a read frame.
    function automatic slot_e read_slot(input int pre_len, input int k);
        int ta0;
        ta0 = pre_len + 4 + PHY_W + REG_W;
        if (k < ta0)                return SL_HDR;
        else if (k == ta0)          return SL_TA;
        else if (k <= ta0 + DATA_W) return SL_RDATA;
        else                        return SL_TAIL;
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
// Module: mdio_mdc_gen
// Divides the system clock into MDC. While run_i is high each low and each
// high phase lasts div_i clocks (0 selects DEF_DIV); bit_end_o marks the last
// clock of a high phase, which is where a bit is sampled and the next one
// is launched. Assumes div_i is held stable while run_i is high.
module mdio_mdc_gen #(
    parameter int DIV_W   = 8,
    parameter int DEF_DIV = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             bit_end_o
);

    logic [DIV_W-1:0] cnt_q;
    logic             phase_q;
    logic [DIV_W-1:0] div_eff;
    logic             term;

    // Pick the programmed phase length or the built-in default.
    always_comb begin
        div_eff = (div_i == '0) ? DIV_W'(DEF_DIV) : div_i;
        term    = (cnt_q == div_eff - 1'b1);
    end

    // Phase counter and MDC level; held at rest while not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (term) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign mdc_o     = phase_q;
    assign bit_end_o = run_i && phase_q && term;

    // R10
    phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < div_eff));

    // R10
    mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && !$past(term)) |-> $stable(mdc_o));

endmodule

// File: rtl/mdio_seq.sv
// Module: mdio_seq
// Frame sequencer: accepts a request while idle, walks the MDC cycle index,
// launches the pad value for each cycle at the end of the previous high
// phase, samples the PHY at the end of each high phase on reads, and runs
// the recovery tail after a bad turnaround. Assumes mdio_i is already
// synchronous to clk.
module mdio_seq
    import mdio_master_pkg::*;
#(
    parameter int PRE_LEN   = 32,
    parameter int RECOV_LEN = 32,
    parameter int DIV_W     = 8,
    parameter int IDX_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_read_i,
    input  logic [PHY_W-1:0]  req_phy_i,
    input  logic [REG_W-1:0]  req_reg_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              bit_end_i,
    input  logic              mdio_i,
    output logic              busy_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              done_o,
    output logic              err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              mdio_o,
    output logic              mdio_oe_o
);

    localparam int TA0       = PRE_LEN + 4 + PHY_W + REG_W;
    localparam int LAST_NORM = TA0 + 2 + DATA_W;
    localparam int LAST_REC  = TA0 + RECOV_LEN;

    logic              busy_q;
    logic              rd_q;
    logic              recov_q;
    logic [IDX_W-1:0]  idx_q;
    logic [PHY_W-1:0]  phy_q;
    logic [REG_W-1:0]  reg_q;
    logic [DATA_W-1:0] wd_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic              err_q;
    drive_t            drv_q;

    int     k;
    logic   accept;
    logic   last_bit;
    slot_e  slot;

    // Decode the current cycle: acceptance, its receive role, frame end.
    always_comb begin
        k        = int'(idx_q);
        accept   = req_valid_i && !busy_q;
        slot     = read_slot(PRE_LEN, k);
        last_bit = (k == ((rd_q && recov_q) ? LAST_REC : LAST_NORM));
    end

    // Request capture, cycle walk, pad launch, read capture and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            rd_q    <= 1'b0;
            recov_q <= 1'b0;
            idx_q   <= '0;
            phy_q   <= '0;
            reg_q   <= '0;
            wd_q    <= '0;
            div_q   <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            drv_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                busy_q  <= 1'b1;
                rd_q    <= req_read_i;
                recov_q <= 1'b0;
                idx_q   <= '0;
                phy_q   <= req_phy_i;
                reg_q   <= req_reg_i;
                wd_q    <= req_wdata_i;
                div_q   <= div_i;
                rdata_q <= '0;
                err_q   <= 1'b0;
                drv_q   <= frame_drive(PRE_LEN, req_read_i, req_phy_i,
                                       req_reg_i, req_wdata_i, 0);
            end else if (busy_q && bit_end_i) begin
                if (rd_q && slot == SL_TA && mdio_i) begin
                    recov_q <= 1'b1;
                end
                if (rd_q && !recov_q && slot == SL_RDATA) begin
                    rdata_q <= {rdata_q[DATA_W-2:0], mdio_i};
                end
                if (last_bit) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    err_q  <= recov_q;
                    idx_q  <= '0;
                    drv_q  <= '0;
                end else begin
                    idx_q  <= idx_q + 1'b1;
                    drv_q  <= frame_drive(PRE_LEN, rd_q, phy_q, reg_q,
                                          wd_q, k + 1);
                end
            end
        end
    end

    assign busy_o    = busy_q;
    assign div_o     = div_q;
    assign done_o    = done_q;
    assign err_o     = err_q;
    assign rdata_o   = rdata_q;
    assign mdio_o    = drv_q.o;
    assign mdio_oe_o = drv_q.oe;

    // R2
    busy_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && req_valid_i) |=> ($stable(phy_q) && $stable(reg_q) &&
                                     $stable(rd_q) && $stable(div_q)));

    // R7
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && rd_q && k >= TA0) |-> !mdio_oe_o);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);

    // R12
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !accept) |=> ($stable(rdata_q) && $stable(err_q)));

    // R8
    recov_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && err_q) |-> (rdata_q == '0));

endmodule

// File: rtl/mdio_master.sv
// Module: mdio_master
// Top of the management frame master: ties the MDC divider to the frame
// sequencer and brings out the three pad signals. Assumes mdio_i has been
// brought into the clk domain before it reaches this block.
module mdio_master
    import mdio_master_pkg::*;
#(
    parameter int PRE_LEN     = 32,
    parameter int RECOV_LEN   = 32,
    parameter int DIV_W       = 8,
    parameter int SYS_CLK_KHZ = 100000,
    parameter int MDC_MAX_KHZ = 2500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic             req_read_i,
    input  logic [4:0]       req_phy_i,
    input  logic [4:0]       req_reg_i,
    input  logic [15:0]      req_wdata_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [15:0]      rdata_o,
    output logic             mdc_o,
    output logic             mdio_o,
    output logic             mdio_oe_o,
    input  logic             mdio_i
);

    localparam int DEF_DIV = (SYS_CLK_KHZ + 2 * MDC_MAX_KHZ - 1) / (2 * MDC_MAX_KHZ);
    localparam int MAX_IDX = PRE_LEN + 4 + PHY_W + REG_W + RECOV_LEN + DATA_W + 2;
    localparam int IDX_W   = $clog2(MAX_IDX + 1);

    logic             busy;
    logic [DIV_W-1:0] div_cur;
    logic             bit_end;

    // Clock divider for MDC.
    mdio_mdc_gen #(
        .DIV_W   (DIV_W),
        .DEF_DIV (DEF_DIV)
    ) mdc_gen_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (busy),
        .div_i     (div_cur),
        .mdc_o     (mdc_o),
        .bit_end_o (bit_end)
    );

    // Frame sequencer.
    mdio_seq #(
        .PRE_LEN   (PRE_LEN),
        .RECOV_LEN (RECOV_LEN),
        .DIV_W     (DIV_W),
        .IDX_W     (IDX_W)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_read_i  (req_read_i),
        .req_phy_i   (req_phy_i),
        .req_reg_i   (req_reg_i),
        .req_wdata_i (req_wdata_i),
        .div_i       (div_i),
        .bit_end_i   (bit_end),
        .mdio_i      (mdio_i),
        .busy_o      (busy),
        .div_o       (div_cur),
        .done_o      (done_o),
        .err_o       (err_o),
        .rdata_o     (rdata_o),
        .mdio_o      (mdio_o),
        .mdio_oe_o   (mdio_oe_o)
    );

    assign busy_o = busy;

    // R11
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mdc_o);

    // R9
    mdio_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> !mdio_oe_o);

endmodule

// File: tb/mdio_master_tb_top.sv
// Bench for mdio_master: a behavioural PHY answers reads, every MDC cycle
// is captured at its rising edge and compared with a frame built from the
// request; phase lengths, line stability and handshake are checked too.
module mdio_master_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_read;
    logic [4:0]  req_phy;
    logic [4:0]  req_reg;
    logic [15:0] req_wdata;
    logic [7:0]  div;
    logic        busy, done, err, mdc, mdo, mdoe;
    logic [15:0] rdata;
    logic        mdi;

    always #5 clk = ~clk;

    mdio_master dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_read_i(req_read),
        .req_phy_i(req_phy), .req_reg_i(req_reg), .req_wdata_i(req_wdata),
        .div_i(div), .busy_o(busy), .done_o(done), .err_o(err), .rdata_o(rdata),
        .mdc_o(mdc), .mdio_o(mdo), .mdio_oe_o(mdoe), .mdio_i(mdi)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // monitor state
    logic clr = 1'b0;
    logic prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;
    int   rises, falls, hi, lo, phase_bad, r9_bad, dones, exp_div;
    logic cap_oe [0:127];
    logic cap_o  [0:127];
    logic done_busy, got_err;
    logic [15:0] got_rd;
    // PHY model state
    logic        phy_rd, phy_ta_bad;
    logic [15:0] phy_data;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic phy_val(input int n);
        if (phy_rd && n == 46) return phy_ta_bad;
        if (phy_rd && n >= 47 && n <= 62) return phy_data[62 - n];
        return 1'b1;
    endfunction

    // Monitor: runs at falling clk edges, away from design updates.
    always @(negedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
        if (clr) begin
            rises = 0; falls = 0; hi = 0; lo = 0; phase_bad = 0;
            r9_bad = 0; dones = 0; clr = 1'b0;
        end else begin
            if (mdc && prev_mdc && (mdo != prev_o || mdoe != prev_oe)) r9_bad++;
            if (mdc && !prev_mdc) begin
                if (rises < 128) begin
                    cap_oe[rises] = mdoe;
                    cap_o[rises]  = mdo;
                end
                rises++;
                if (lo != exp_div) phase_bad++;
                lo = 0;
            end
            if (!mdc && prev_mdc) begin
                falls++;
                mdi = phy_val(falls);
                if (hi != exp_div) phase_bad++;
                hi = 0;
            end
            if (busy) begin
                if (mdc) hi++;
                else lo++;
            end
            if (done) begin
                dones++;
                done_busy = busy;
                got_err = err;
                got_rd = rdata;
            end
        end
        prev_mdc = mdc;
        prev_o = mdo;
        prev_oe = mdoe;
    end

    // Run one frame and check it against an arithmetically built frame.
    task automatic run_frame(input logic rd, input logic [4:0] phy,
                             input logic [4:0] ra, input logic [15:0] wd,
                             input logic [7:0] dv, input logic ta_bad,
                             input logic [15:0] pdata, input bit inject);
        logic [45:0] hdr;
        logic [17:0] wbody;
        int          bad_pre, bad_st, bad_addr, bad_body, exp_rises, tmo;
        bit          seen;
        hdr   = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra};
        wbody = {2'b10, wd};
        @(negedge clk);
        #1;
        clr = 1'b1;
        exp_div = (dv == 8'd0) ? 20 : int'(dv);
        phy_rd = rd; phy_ta_bad = ta_bad; phy_data = pdata;
        mdi = 1'b1;
        @(negedge clk);
        #1;
        req_valid = 1'b1; req_read = rd; req_phy = phy; req_reg = ra;
        req_wdata = wd; div = dv;
        @(negedge clk);
        chk(busy == 1'b1, "R11", "busy after accept", int'(busy), 1);
        #1;
        req_valid = 1'b0;
        if (inject) begin
            repeat (40) @(negedge clk);
            #1;
            req_valid = 1'b1; req_read = ~rd; req_phy = ~phy; req_reg = ~ra;
            req_wdata = ~wd; div = dv + 8'd3;
            @(negedge clk);
            #1;
            req_valid = 1'b0;
        end
        seen = 1'b0;
        tmo = 0;
        while (!seen && tmo < 8000) begin
            @(negedge clk);
            tmo++;
            if (done) seen = 1'b1;
        end
        chk(seen, "R11", "done seen", int'(seen), 1);
        repeat (3) @(negedge clk);
        bad_pre = 0; bad_st = 0; bad_addr = 0; bad_body = 0;
        for (int k = 0; k < 46; k++) begin
            if (cap_oe[k] !== 1'b1 || cap_o[k] !== hdr[45-k]) begin
                if (k < 32) bad_pre++;
                else if (k < 36) bad_st++;
                else bad_addr++;
            end
        end
        exp_rises = (rd && ta_bad) ? 79 : 65;
        for (int k = 46; k < exp_rises && k < 128; k++) begin
            if (rd) begin
                if (cap_oe[k] !== 1'b0) bad_body++;
            end else if (k < 64) begin
                if (cap_oe[k] !== 1'b1 || cap_o[k] !== wbody[63-k]) bad_body++;
            end else begin
                if (cap_oe[k] !== 1'b0) bad_body++;
            end
        end
        chk(bad_pre == 0, "R3", "preamble mismatches", bad_pre, 0);
        chk(bad_st == 0, "R4", "start/direction mismatches", bad_st, 0);
        chk(bad_addr == 0, "R5", "address mismatches", bad_addr, 0);
        if (rd) chk(bad_body == 0, "R7", "read release mismatches", bad_body, 0);
        else    chk(bad_body == 0, "R6", "write body mismatches", bad_body, 0);
        if (rd && ta_bad) chk(rises == exp_rises, "R8", "mdc cycles", rises, exp_rises);
        else if (rd)      chk(rises == exp_rises, "R7", "mdc cycles", rises, exp_rises);
        else              chk(rises == exp_rises, "R6", "mdc cycles", rises, exp_rises);
        chk(r9_bad == 0, "R9", "changes while mdc high", r9_bad, 0);
        chk(phase_bad == 0, "R10", "phase length errors", phase_bad, 0);
        chk(dones == 1 && done_busy == 1'b0, "R11", "done pulses / busy at done",
            dones * 10 + int'(done_busy), 10);
        chk(mdc == 1'b0 && mdoe == 1'b0, "R11", "idle mdc/oe", int'({mdc, mdoe}), 0);
        if (inject) chk(dones == 1 && rises == exp_rises && bad_body == 0, "R2",
                        "mid-frame request ignored", rises, exp_rises);
        if (rd && ta_bad) begin
            chk(got_err == 1'b1, "R8", "err at done", int'(got_err), 1);
            chk(got_rd == 16'h0, "R8", "rdata after error", int'(got_rd), 0);
        end else if (rd) begin
            chk(got_err == 1'b0, "R7", "err at done", int'(got_err), 0);
            chk(got_rd == pdata, "R7", "rdata", int'(got_rd), int'(pdata));
        end
        repeat (5) @(negedge clk);
        chk(rdata == got_rd && err == got_err, "R12", "result held",
            int'(rdata), int'(got_rd));
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_read = 1'b0; req_phy = '0; req_reg = '0;
        req_wdata = '0; div = 8'd1; mdi = 1'b1;
        phy_rd = 1'b0; phy_ta_bad = 1'b0; phy_data = '0; exp_div = 1;
        repeat (4) @(negedge clk);
        // R1: outputs in reset
        chk(busy == 0 && done == 0 && err == 0 && mdc == 0 && mdoe == 0, "R1",
            "reset outputs", int'({busy, done, err, mdc, mdoe}), 0);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && mdc == 0 && mdoe == 0, "R1", "idle after reset",
            int'({busy, mdc, mdoe}), 0);

        // Writes: every PHY address, mirrored register addresses (R5, R6)
        for (int a = 0; a < 32; a++) begin
            run_frame(1'b0, 5'(a), 5'(31 - a), 16'((a * 2053) ^ 16'hA5C3),
                      8'(1 + (a % 3)), 1'b0, 16'h0, 1'b0);
        end
        // Reads: every register address, walking data (R5, R7)
        for (int r = 0; r < 32; r++) begin
            run_frame(1'b1, 5'(r ^ 5), 5'(r), 16'h0, 8'(1 + (r % 2)), 1'b0,
                      16'((16'h1 << (r % 16)) ^ (r * 16'h0111)), 1'b0);
        end
        // R8: bad turnaround at two dividers
        run_frame(1'b1, 5'd3, 5'd17, 16'h0, 8'd1, 1'b1, 16'hBEEF, 1'b0);
        run_frame(1'b1, 5'd30, 5'd2, 16'h0, 8'd3, 1'b1, 16'h1234, 1'b0);
        // R7 after recovery: a good read works again
        run_frame(1'b1, 5'd31, 5'd31, 16'h0, 8'd2, 1'b0, 16'hFFFF, 1'b0);
        // R10: default divider
        run_frame(1'b0, 5'd9, 5'd4, 16'h8001, 8'd0, 1'b0, 16'h0, 1'b0);
        // R2: request and divider change while busy
        run_frame(1'b1, 5'd12, 5'd6, 16'h0, 8'd2, 1'b0, 16'h5AA5, 1'b1);
        run_frame(1'b0, 5'd21, 5'd11, 16'h0F0F, 8'd4, 1'b0, 16'h0, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule